// File: doc/BRIEF.md
# Receive Word Queue with Combined Level Interrupt

This block sits behind a serial receive shift register. Each time the shifter completes a word it pulses a write strobe, and the word goes into a small first-in first-out store of four entries. Software or a DMA engine drains the store through a read strobe. Each accepted read places the oldest word on a registered output, and that value stays there until the next accepted read.

One interrupt line covers three reasons for service. The first is a fill count that has reached a programmable level. The second is a receive error reported by the shifter. The third is a sticky overflow flag, which is set when a word arrives and no entry is free. A clear input holds the queue empty for as long as it is set, and the queue restarts from empty once the input is released. The level register resets to all ones, so by default the fill count never triggers the interrupt until software writes a lower level.

Top module: `rx_word_queue`

## Requirements
- R1: After reset the fill count is 0, the overflow flag is 0, the interrupt is 0 and the read data is 0.
- R2: The fill count always equals the number of words held and never exceeds 4. An accepted write adds one, an accepted read removes one, and both together leave the count unchanged.
- R3: Words are returned in the order they were written. The read data updates on the clock edge that accepts the read.
- R4: A read strobe while the queue is empty leaves the read data at the last value read and leaves the count at 0.
- R5: A write strobe while 4 words are held, with no read in the same cycle, discards the word, keeps the count at 4 and sets the overflow flag on the next edge.
- R6: The overflow flag stays set until the overflow-clear input is high at a clock edge. A new overflow in the same cycle as a clear wins.
- R7: A write and a read in the same cycle while full are both accepted. The count stays 4, the overflow flag does not set, and the new word becomes the newest entry.
- R8: While the queue-clear input is high, the count is 0 from the next edge and writes are ignored. After release the queue fills again from empty.
- R9: The interrupt is high whenever the fill count is greater than or equal to the trigger level, compared as unsigned 5-bit values.
- R10: The interrupt is also high whenever the receive error input is high or the overflow flag is set.
- R11: The trigger level resets to 31 (all ones in 5 bits) and takes the level input on a clock edge where the level-write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | Word-complete strobe from the shifter |
| wr_data | input | 16 | Received word |
| rd_stb | input | 1 | Read strobe |
| q_clr | input | 1 | Hold the queue empty while high |
| lvl_wr | input | 1 | Load the trigger level |
| lvl_in | input | 5 | New trigger level |
| ovf_clr | input | 1 | Clear the overflow flag |
| rx_err | input | 1 | Receive error from the shifter |
| rd_data | output | 16 | Last word read |
| fill_cnt | output | 3 | Number of words held |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Combined receive interrupt |

## Verification
On every cycle, the assertions check the following: the count bound, the emptying effect of the clear input, the stable read data on an empty read, the setting and stickiness of the overflow flag, the no-overflow rule for a read and write together when full, and the three sources that drive the interrupt. Only the bench scenarios can show that the words come out in the order they went in, including a word accepted at the same time as a read while full. The scenarios also show that a discarded word never reappears, that the queue restarts cleanly from empty after a clear, and that the threshold comparison follows a level written at run time.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  // What the store does on an edge
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } rxq_op_e;
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_evt
);

  logic [PTR_W-1:0]  wp_q, wp_n, rp_q, rp_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] dout_q, dout_n;
  logic              empty, full, push_ok, pop_ok;
  rxq_op_e           op;
  logic [DATA_W-1:0] ent_w [DEPTH];

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CNT_W'(DEPTH));
    pop_ok  = pop_req && !clr && !empty;
    push_ok = push_req && !clr && (!full || pop_ok);
    ovf_evt = push_req && !clr && full && !pop_ok;
    op      = rxq_op_e'({push_ok, pop_ok});
  end

  // Entry storage, one register per slot, no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    logic              ent_en;
    assign ent_en = push_ok && (wp_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (ent_en) ent_q <= din;
    end
    assign ent_w[g] = ent_q;
  end

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n   = wp_q;
    rp_n   = rp_q;
    cnt_n  = cnt_q;
    dout_n = dout_q;
    case (op)
      OP_PUSH: begin
        wp_n  = ptr_inc(wp_q);
        cnt_n = cnt_q + 1'b1;
      end
      OP_POP: begin
        rp_n   = ptr_inc(rp_q);
        cnt_n  = cnt_q - 1'b1;
        dout_n = ent_w[rp_q];
      end
      OP_BOTH: begin
        wp_n   = ptr_inc(wp_q);
        rp_n   = ptr_inc(rp_q);
        dout_n = ent_w[rp_q];
      end
      default: ;
    endcase
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      dout_q <= '0;
    end else begin
      wp_q   <= wp_n;
      rp_q   <= rp_n;
      cnt_q  <= cnt_n;
      dout_q <= dout_n;
    end
  end

  assign dout  = dout_q;
  assign count = cnt_q;

  p_cnt_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_clr_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  p_empty_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !clr) |=> $stable(dout_q));

endmodule

// File: rtl/rxq_flags.sv
`timescale 1ns/1ps
module rxq_flags #(
  parameter int LVL_W = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_wr,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic             ovf_set,
  input  logic             ovf_clr,
  input  logic             rx_err,
  input  logic [CNT_W-1:0] count,
  output logic [LVL_W-1:0] level,
  output logic             ovf,
  output logic             irq
);

  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             ovf_q, ovf_n;
  logic             at_level;

  always_comb begin
    lvl_n = lvl_wr ? lvl_in : lvl_q;
    if (ovf_set)      ovf_n = 1'b1;
    else if (ovf_clr) ovf_n = 1'b0;
    else              ovf_n = ovf_q;
    at_level = (LVL_W'(count) >= lvl_q);
    irq      = at_level || rx_err || ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '1;
      ovf_q <= 1'b0;
    end else begin
      lvl_q <= lvl_n;
      ovf_q <= ovf_n;
    end
  end

  assign level = lvl_q;
  assign ovf   = ovf_q;

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  p_lvl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_wr |=> $stable(lvl_q));

endmodule

// File: rtl/rx_word_queue.sv
`timescale 1ns/1ps
module rx_word_queue #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              q_clr,
  input  logic              lvl_wr,
  input  logic [LVL_W-1:0]  lvl_in,
  input  logic              ovf_clr,
  input  logic              rx_err,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic              ovf_flag,
  output logic              irq
);

  // Reset: asserted at once, released on the second edge
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic             ovf_evt;
  logic [LVL_W-1:0] level;

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr      (q_clr),
    .push_req (wr_stb),
    .pop_req  (rd_stb),
    .din      (wr_data),
    .dout     (rd_data),
    .count    (fill_cnt),
    .ovf_evt  (ovf_evt)
  );

  rxq_flags #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .lvl_wr  (lvl_wr),
    .lvl_in  (lvl_in),
    .ovf_set (ovf_evt),
    .ovf_clr (ovf_clr),
    .rx_err  (rx_err),
    .count   (fill_cnt),
    .level   (level),
    .ovf     (ovf_flag),
    .irq     (irq)
  );

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_stb && !rd_stb && !q_clr && fill_cnt == CNT_W'(DEPTH))
      |=> (ovf_flag && fill_cnt == CNT_W'(DEPTH)));
  p_full_both_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_stb && rd_stb && !q_clr && !ovf_flag && fill_cnt == CNT_W'(DEPTH))
      |=> (!ovf_flag && fill_cnt == CNT_W'(DEPTH)));
  p_irq_lvl_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (LVL_W'(fill_cnt) >= level) |-> irq);
  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rx_err || ovf_flag) |-> irq);

endmodule

// File: tb/sim_rx_word_queue.sv
`timescale 1ns/1ps
module sim_rx_word_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb, rd_stb, q_clr, lvl_wr, ovf_clr, rx_err;
  logic [15:0] wr_data;
  logic [4:0]  lvl_in;
  logic [15:0] rd_data;
  logic [2:0]  fill_cnt;
  logic        ovf_flag, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  rx_word_queue u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .q_clr(q_clr), .lvl_wr(lvl_wr), .lvl_in(lvl_in),
    .ovf_clr(ovf_clr), .rx_err(rx_err), .rd_data(rd_data),
    .fill_cnt(fill_cnt), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic step(input logic w, input logic [15:0] d, input logic r);
    wr_stb = w; wr_data = d; rd_stb = r;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic set_level(input logic [4:0] l);
    lvl_in = l; lvl_wr = 1'b1;
    @(negedge clk);
    lvl_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", fill_cnt, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_order;
    for (int i = 0; i < 4; i++) step(1'b1, 16'hA000 + 16'(i), 1'b0);
    chk("R2 count full", fill_cnt, 4);
    chk("R11 default level no irq", irq, 0);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 16'h0, 1'b1);
      chk("R3 order", rd_data, 16'hA000 + i);
      chk("R2 count down", fill_cnt, 3 - i);
    end
  endtask

  task automatic t_empty_read;
    step(1'b0, 16'h0, 1'b1);
    chk("R4 rd_data held", rd_data, 16'hA003);
    chk("R4 count", fill_cnt, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 4; i++) step(1'b1, 16'hB000 + 16'(i), 1'b0);
    step(1'b1, 16'hBEEF, 1'b0);
    chk("R5 count", fill_cnt, 4);
    chk("R5 ovf", ovf_flag, 1);
    chk("R10 irq by ovf", irq, 1);
    repeat (3) @(negedge clk);
    chk("R6 sticky", ovf_flag, 1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 16'h0, 1'b1);
      chk("R5 word discarded", rd_data, 16'hB000 + i);
    end
    chk("R6 still set when empty", ovf_flag, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R6 cleared", ovf_flag, 0);
    chk("R10 irq drops", irq, 0);
  endtask

  task automatic t_full_both;
    for (int i = 0; i < 4; i++) step(1'b1, 16'hC000 + 16'(i), 1'b0);
    step(1'b1, 16'hC004, 1'b1);
    chk("R7 rd_data", rd_data, 16'hC000);
    chk("R7 count", fill_cnt, 4);
    chk("R7 no ovf", ovf_flag, 0);
    for (int i = 1; i < 5; i++) begin
      step(1'b0, 16'h0, 1'b1);
      chk("R7 order", rd_data, 16'hC000 + i);
    end
    chk("R2 empty", fill_cnt, 0);
  endtask

  task automatic t_clear;
    step(1'b1, 16'hD000, 1'b0);
    step(1'b1, 16'hD001, 1'b0);
    q_clr = 1'b1;
    step(1'b1, 16'hD002, 1'b0);
    chk("R8 count cleared", fill_cnt, 0);
    step(1'b1, 16'hD003, 1'b0);
    chk("R8 write ignored", fill_cnt, 0);
    q_clr = 1'b0;
    step(1'b1, 16'hD055, 1'b0);
    chk("R8 refill", fill_cnt, 1);
    step(1'b0, 16'h0, 1'b1);
    chk("R8 from empty", rd_data, 16'hD055);
  endtask

  task automatic t_level;
    set_level(5'd2);
    chk("R9 below level", irq, 0);
    step(1'b1, 16'hE000, 1'b0);
    chk("R9 one word", irq, 0);
    step(1'b1, 16'hE001, 1'b0);
    chk("R9 at level", irq, 1);
    step(1'b0, 16'h0, 1'b1);
    chk("R9 below again", irq, 0);
    step(1'b0, 16'h0, 1'b1);
    set_level(5'd0);
    chk("R9 level zero empty", irq, 1);
    set_level(5'd31);
    chk("R11 level restored", irq, 0);
  endtask

  task automatic t_error;
    rx_err = 1'b1;
    #2;
    chk("R10 irq by error", irq, 1);
    rx_err = 1'b0;
    #2;
    chk("R10 irq off", irq, 0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_stb = 0; rd_stb = 0; q_clr = 0; lvl_wr = 0;
    ovf_clr = 0; rx_err = 0; wr_data = '0; lvl_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_order();
    t_empty_read();
    t_overflow();
    t_full_both();
    t_clear();
    t_level();
    t_error();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule